// File: doc/BRIEF.md
# Packed Lane Bit Shifter

This block is the shift unit of a 64-bit SIMD datapath. It takes a 64-bit operand and moves its bits left or right by a count. The operand can be split into four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. Each lane shifts on its own. A left shift or a logical right shift fills the emptied positions with zeros. An arithmetic right shift fills the emptied top positions with copies of that lane's sign bit.

The count has two possible sources: an 8-bit immediate, or a full 64-bit count operand. The whole count operand is used as an unsigned number. A count equal to or larger than the lane width empties the lane completely. After a cycle with a valid input, the result is registered and flagged valid on the next clock edge. Instruction decode, operand fetch and writeback belong to the surrounding pipeline.

Top module: `lane_shifter`

## Requirements
- R1: A synchronous active-high reset clears out_data to zero and out_valid to 0.
- R2: In the cycle after a clock edge with in_valid high, out_valid is 1 and out_data holds the result. After an edge with in_valid low, out_valid is 0 and out_data keeps its previous value.
- R3: in_lane selects the lane size: 0 gives four 16-bit lanes, 1 gives two 32-bit lanes, and 2 or 3 gives one 64-bit lane. Lane 0 sits in the least significant bits. No bit ever crosses into a neighbouring lane.
- R4: When in_right is 0, every lane shifts toward its most significant bit, and the emptied low positions are filled with 0.
- R5: When in_right is 1 and in_arith is 0, every lane shifts toward its least significant bit, and the emptied high positions are filled with 0.
- R6: When in_right is 1 and in_arith is 1, 16-bit and 32-bit lanes shift right, and the emptied high positions are filled with that lane's original top bit.
- R7: When the lane size is 64 bits, an arithmetic request (in_right=1, in_arith=1) gives a logical right shift with zero fill.
- R8: When in_use_imm is 1, the count is in_imm zero-extended. When in_use_imm is 0, the count is the full unsigned 64-bit in_count_reg.
- R9: A count at or above the lane width gives all-zero lanes for left and logical shifts, and lanes filled entirely with their sign bit for arithmetic shifts. This includes counts whose only set bits lie above bit 7.
- R10: in_arith has no effect when in_right is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The operands on this cycle are to be shifted |
| in_data | input | 64 | Operand to shift |
| in_count_reg | input | 64 | Count taken from the 64-bit count operand |
| in_imm | input | 8 | Count taken from the immediate |
| in_use_imm | input | 1 | 1 selects in_imm as the count, 0 selects in_count_reg |
| in_right | input | 1 | 0 shifts left, 1 shifts right |
| in_arith | input | 1 | For a right shift, 1 fills with the sign bit |
| in_lane | input | 2 | Lane size: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 64 | Registered shift result |

## Verification
Every direction and lane size is driven with operands whose lanes have different top bits. Because of that, a sign taken from the wrong lane, or a bit leaking across a lane edge, changes the result. Counts just below, at, and above each lane width separate correct out-of-range fill from a wrapped count. One 64-bit count has only bit 32 set, so the bench can tell whether the full count is used or only its low bits. The same count is also given once as an immediate and once as the count operand, which shows the count source select works.

// File: rtl/lane_shifter_pkg.sv
package lane_shifter_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned CNT_W   = 64;
    localparam int unsigned IMM_W   = 8;
    localparam int unsigned AMT_W   = $clog2(DATA_W) + 1;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned WORD_W  = 32;

    typedef enum logic [1:0] {
        LANE_H = 2'd0,
        LANE_W = 2'd1,
        LANE_Q = 2'd2,
        LANE_Q2 = 2'd3
    } lane_e;

    typedef struct packed {
        logic right;
        logic arith;
    } shift_op_t;

    typedef logic [AMT_W-1:0] amt_t;

    function automatic amt_t clamp_count(input logic [CNT_W-1:0] c);
        if (c >= CNT_W'(DATA_W))
            return amt_t'(DATA_W);
        return c[AMT_W-1:0];
    endfunction

endpackage

// File: rtl/count_select.sv
module count_select
    import lane_shifter_pkg::*;
(
    input  logic [CNT_W-1:0] count_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output amt_t             amount
);
    logic [CNT_W-1:0] full;

    always_comb begin
        full   = use_imm ? CNT_W'(imm) : count_reg;
        amount = clamp_count(full);
    end
endmodule

// File: rtl/lane_unit.sv
module lane_unit
    import lane_shifter_pkg::*;
#(
    parameter int unsigned LW = 16,
    parameter bit          ALLOW_ARITH = 1'b1
) (
    input  logic [LW-1:0] din,
    input  amt_t          amount,
    input  shift_op_t     op,
    output logic [LW-1:0] dout
);
    localparam amt_t LW_AMT = amt_t'(LW);

    logic          over;
    logic          sgn;
    logic          fill_sign;

    always_comb begin
        over      = (amount >= LW_AMT);
        sgn       = din[LW-1];
        fill_sign = ALLOW_ARITH && op.right && op.arith;
        if (!op.right)
            dout = over ? '0 : (din << amount);
        else if (fill_sign)
            dout = over ? {LW{sgn}} : LW'($signed(din) >>> amount);
        else
            dout = over ? '0 : (din >> amount);
    end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import lane_shifter_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_data,
    input  logic [63:0] in_count_reg,
    input  logic [7:0]  in_imm,
    input  logic        in_use_imm,
    input  logic        in_right,
    input  logic        in_arith,
    input  logic [1:0]  in_lane,
    output logic        out_valid,
    output logic [63:0] out_data
);
    localparam int unsigned N_H = DATA_W / HALF_W;
    localparam int unsigned N_W = DATA_W / WORD_W;

    amt_t             amount;
    shift_op_t        op;
    lane_e            lane;
    logic [DATA_W-1:0] res_h, res_w, res_q, res_sel;

    assign op.right = in_right;
    assign op.arith = in_arith;
    assign lane     = lane_e'(in_lane);

    count_select u_cnt (
        .count_reg (in_count_reg),
        .imm       (in_imm),
        .use_imm   (in_use_imm),
        .amount    (amount)
    );

    for (genvar g = 0; g < N_H; g++) begin : g_half
        lane_unit #(.LW(HALF_W), .ALLOW_ARITH(1'b1)) u_lane (
            .din    (in_data[g*HALF_W +: HALF_W]),
            .amount (amount),
            .op     (op),
            .dout   (res_h[g*HALF_W +: HALF_W])
        );
    end

    for (genvar g = 0; g < N_W; g++) begin : g_word
        lane_unit #(.LW(WORD_W), .ALLOW_ARITH(1'b1)) u_lane (
            .din    (in_data[g*WORD_W +: WORD_W]),
            .amount (amount),
            .op     (op),
            .dout   (res_w[g*WORD_W +: WORD_W])
        );
    end

    lane_unit #(.LW(DATA_W), .ALLOW_ARITH(1'b0)) u_quad (
        .din    (in_data),
        .amount (amount),
        .op     (op),
        .dout   (res_q)
    );

    always_comb begin
        unique case (lane)
            LANE_H:  res_sel = res_h;
            LANE_W:  res_sel = res_w;
            default: res_sel = res_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= res_sel;
        end
    end

    logic big16, big32;
    assign big16 = in_use_imm ? (in_imm >= 8'd16) : (in_count_reg >= 64'd16);
    assign big32 = in_use_imm ? (in_imm >= 8'd32) : (in_count_reg >= 64'd32);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R1
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data))); // R2
    AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_lane == 2'd0 && !in_right && big16) |=> out_data == '0); // R9
    AST_WORD_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_lane == 2'd1 && in_right && in_arith && big32) |=>
        out_data == {{32{$past(in_data[63])}}, {32{$past(in_data[31])}}}); // R6
endmodule

// File: tb/lane_shifter_tb.sv
module lane_shifter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_data, in_count_reg;
    logic [7:0]  in_imm;
    logic        in_use_imm, in_right, in_arith;
    logic [1:0]  in_lane;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lane_shifter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_count_reg(in_count_reg), .in_imm(in_imm), .in_use_imm(in_use_imm),
        .in_right(in_right), .in_arith(in_arith), .in_lane(in_lane),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] expect_shift(logic [63:0] d, logic [63:0] c,
                                                 logic right, logic arith, logic [1:0] lane);
        logic [63:0] r;
        int lw;
        int ci;
        lw = (lane == 2'd0) ? 16 : (lane == 2'd1) ? 32 : 64;
        ci = (c < 64'(lw)) ? int'(c) : lw;
        r  = '0;
        for (int b = 0; b < 64; b += lw) begin
            for (int i = 0; i < lw; i++) begin
                if (!right)
                    r[b+i] = (i >= ci) ? d[b+i-ci] : 1'b0;
                else if (i + ci < lw)
                    r[b+i] = d[b+i+ci];
                else
                    r[b+i] = (arith && lw != 64) ? d[b+lw-1] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0; in_data = '0; in_count_reg = '0; in_imm = '0;
        in_use_imm = 1'b0; in_right = 1'b0; in_arith = 1'b0; in_lane = 2'd0;
    endtask

    task automatic shot(string req, logic [63:0] d, logic [63:0] creg, logic [7:0] imm,
                        logic use_imm, logic right, logic arith, logic [1:0] lane,
                        logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_count_reg = creg; in_imm = imm;
        in_use_imm = use_imm; in_right = right; in_arith = arith; in_lane = lane;
        @(negedge clk);
        drive_idle();
        check(req, out_data, exp);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic shot_ref(string req, logic [63:0] d, logic [63:0] c,
                            logic right, logic arith, logic [1:0] lane);
        shot(req, d, c, 8'd0, 1'b0, right, arith, lane,
             expect_shift(d, c, right, arith, lane));
    endtask

    localparam logic [63:0] PAT = 64'h8421_7F0F_C003_1234;

    task automatic t_reset();
        rst = 1'b1; drive_idle();
        repeat (2) @(negedge clk);
        check("R1 data", out_data, 64'd0);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_left();
        shot("R4 R3 half left 3", PAT, 64'd3, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0, 64'h2108_F878_0018_91A0);
        for (int ln = 0; ln < 3; ln++)
            for (int c = 1; c < 20; c += 6)
                shot_ref("R4 left sweep", PAT, 64'(c), 1'b0, 1'b0, 2'(ln));
    endtask

    task automatic t_rlog();
        shot("R5 R3 word logical 4", PAT, 64'd4, 8'd0, 1'b0, 1'b1, 1'b0, 2'd1, 64'h0842_17F0_0C00_3123);
        for (int ln = 0; ln < 4; ln++)
            shot_ref("R5 logical sweep", PAT, 64'd9, 1'b1, 1'b0, 2'(ln));
    endtask

    task automatic t_rari();
        shot("R6 half arith 4", PAT, 64'd4, 8'd0, 1'b0, 1'b1, 1'b1, 2'd0, 64'hF842_07F0_FC00_0123);
        shot_ref("R6 word arith 31", PAT, 64'd31, 1'b1, 1'b1, 2'd1);
        shot_ref("R6 half arith 15", PAT, 64'd15, 1'b1, 1'b1, 2'd0);
    endtask

    task automatic t_quad_arith();
        shot("R7 quad arith acts logical", PAT, 64'd8, 8'd0, 1'b0, 1'b1, 1'b1, 2'd2, 64'h0084_217F_0FC0_0312);
        shot("R7 lane code 3", PAT, 64'd8, 8'd0, 1'b0, 1'b1, 1'b1, 2'd3, 64'h0084_217F_0FC0_0312);
    endtask

    task automatic t_count_src();
        shot("R8 imm used", PAT, 64'd0, 8'd5, 1'b1, 1'b0, 1'b0, 2'd2, PAT << 5);
        shot("R8 reg used", PAT, 64'd5, 8'd0, 1'b0, 1'b0, 1'b0, 2'd2, PAT << 5);
        shot("R8 imm 200 quad", PAT, 64'd1, 8'd200, 1'b1, 1'b1, 1'b0, 2'd2, 64'd0);
    endtask

    task automatic t_range();
        shot("R9 half left 16", PAT, 64'd16, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0, 64'd0);
        shot("R9 word arith 32", PAT, 64'd32, 8'd0, 1'b0, 1'b1, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        shot("R9 half arith high bit", PAT, 64'h1_0000_0000, 8'd0, 1'b0, 1'b1, 1'b1, 2'd0, 64'hFFFF_0000_FFFF_0000);
        shot("R9 quad logical high bit", PAT, 64'h1_0000_0001, 8'd0, 1'b0, 1'b1, 1'b0, 2'd2, 64'd0);
        shot("R9 quad left 64", PAT, 64'd64, 8'd0, 1'b0, 1'b0, 1'b0, 2'd2, 64'd0);
        shot("R9 quad left 63", PAT, 64'd63, 8'd0, 1'b0, 1'b0, 1'b0, 2'd2, 64'd0);
    endtask

    task automatic t_arith_left();
        shot("R10 arith ignored on left", PAT, 64'd2, 8'd0, 1'b0, 1'b0, 1'b1, 2'd0, 64'h1084_FC3C_000C_48D0);
    endtask

    task automatic t_hold();
        logic [63:0] prev;
        shot("R2 setup", PAT, 64'd1, 8'd0, 1'b0, 1'b0, 1'b0, 2'd2, PAT << 1);
        prev = out_data;
        @(negedge clk);
        in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_count_reg = 64'd0;
        @(negedge clk);
        check("R2 hold data", out_data, prev);
        check("R2 valid low", {63'd0, out_valid}, 64'd0);
        drive_idle();
    endtask

    initial begin
        t_reset();
        t_left();
        t_rlog();
        t_rari();
        t_quad_arith();
        t_count_src();
        t_range();
        t_arith_left();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule